// File: doc/BRIEF.md
# GPIO Pad Interrupt Multiplexer

This block watches a wide bank of general-purpose input pads and turns activity on any chosen pad into an interrupt on one of eight upstream lines. It does not give every pad its own interrupt. Each of the eight channels holds an 8-bit pad index that picks one pad from a 256-entry index space. Each channel also has a trigger filter, set to edge or level and to one of two polarities. Only the first `NUM_PADS` indices reach real pads. A higher index reads as a pad that never becomes active.

Software sets the channels up through a 16-byte window of four 32-bit word registers, each with its own write enable. All pads pass through a two-flop synchronizer before they reach the channel logic. In level mode the interrupt line follows the pad directly. In edge mode an active edge sets a sticky pending bit, and software clears that bit with a write-1-to-clear register. A change to a channel's configuration clears its pending bit. It also re-seeds the channel's edge history, so the reconfiguration itself cannot raise an interrupt.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset all four registers read 0, every channel is in level mode with active-high polarity and selects pad 0, and `irq_out` is 0.
- R2: Register map, in 32-bit words with `addr[1:0]` equal to 0:
  - 0x0 holds the pad index of channel k (k = 0..3) in bits 8k+7:8k.
  - 0x4 holds the pad index of channel k+4 in the same byte positions.
  - 0x8 holds the per-channel mode in bits 7:0 (1 = edge, 0 = level) and the polarity in bits 23:16 (1 = falling edge or low level, 0 = rising edge or high level).
  - 0xC reads back the pending bits in bits 7:0.
  - All registers read back on `rdata` combinationally.
- R3: In level mode, `irq_out[k]` equals the selected pad XOR polarity. It follows a pad change after exactly two clock edges, with no latching.
- R4: In edge mode, an active edge on the selected pad sets `irq_out[k]` on the third clock edge after the pad change. The output then stays high until it is cleared. An edge in the inactive direction has no effect.
- R5: A write of 1 to bit k at 0xC clears channel k's pending bit, and a write of 0 to a bit leaves that bit unchanged. If an active edge is detected in the same cycle as the clear, the pending bit stays set.
- R6: In level mode, writes to 0xC have no effect on `irq_out`.
- R7: A pad index at or above `NUM_PADS` gives an input that is never active, so `irq_out[k]` stays 0 whatever the polarity or mode.
- R8: A write that changes a channel's pad index, mode or polarity clears that channel's pending bit. The new setting does not raise an interrupt on its own, even when the newly selected pad is already at its active level.
- R9: The channels are independent. Several channels may select the same pad, and each one applies its own filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pads | input | NUM_PADS | Asynchronous pad inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address within the 16-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_out | output | 8 | One interrupt line per channel |

## Verification
The hardest cases to reach are two races. In the first, a software clear lands in the very cycle that the edge detector sets the pending bit. The bench gets there by counting clock edges from a pad change, so that the clear write commits on the third edge. In the second, a reconfiguration points a channel at a pad that is already active. The bench holds the pad active before the write and then waits long enough for any false edge to appear. Random rounds then mix channels, pad indices on both sides of the mapped boundary, modes and polarities. Each round checks both the exact latency and the sticky behaviour.

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux #(
  parameter int NUM_PADS  = 96,
  parameter int IDX_SPACE = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads,
  input  logic                wr_en,
  input  logic [3:0]          addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [7:0]          irq_out
);
  localparam int NCH = 8;
  localparam int SW  = $clog2(IDX_SPACE);
  localparam logic [SW:0] PAD_LIM = (SW+1)'(NUM_PADS);

  logic [NUM_PADS-1:0]     meta_q, sync_q;
  logic [IDX_SPACE-1:0]    pad_ext;
  logic [NCH-1:0][SW-1:0]  sel_q;
  logic [NCH-1:0]          edge_q, pol_q, pend_q, cond;

  wire aligned  = addr[1:0] == 2'd0;
  wire wr_sel_lo = wr_en && aligned && addr[3:2] == 2'd0;
  wire wr_sel_hi = wr_en && aligned && addr[3:2] == 2'd1;
  wire wr_mode   = wr_en && aligned && addr[3:2] == 2'd2;
  wire wr_clr    = wr_en && aligned && addr[3:2] == 2'd3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pads;
      sync_q <= meta_q;
    end

  always_comb begin
    pad_ext = '0;
    pad_ext[NUM_PADS-1:0] = sync_q;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BYTE = (c % 4) * 8;
    logic [SW-1:0] sel_r;
    logic          edge_r, pol_r, pend_r, hist_r, arm_r;

    wire           sel_wr  = (c < 4) ? wr_sel_lo : wr_sel_hi;
    wire [SW-1:0]  sel_new = wdata[BYTE +: SW];
    wire           mapped  = {1'b0, sel_r} < PAD_LIM;
    wire           chg     = (sel_wr && sel_new != sel_r) ||
                             (wr_mode && (wdata[c] != edge_r || wdata[16+c] != pol_r));

    assign cond[c]   = mapped & (pad_ext[sel_r] ^ pol_r);
    assign sel_q[c]  = sel_r;
    assign edge_q[c] = edge_r;
    assign pol_q[c]  = pol_r;
    assign pend_q[c] = pend_r;
    assign irq_out[c] = edge_r ? pend_r : cond[c];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sel_r  <= '0;
        edge_r <= 1'b0;
        pol_r  <= 1'b0;
        pend_r <= 1'b0;
        hist_r <= 1'b0;
        arm_r  <= 1'b1;
      end else begin
        if (sel_wr) sel_r <= sel_new;
        if (wr_mode) begin
          edge_r <= wdata[c];
          pol_r  <= wdata[16+c];
        end
        if (chg) begin
          pend_r <= 1'b0;
          arm_r  <= 1'b1;
        end else begin
          hist_r <= cond[c];
          arm_r  <= 1'b0;
          if (edge_r && !arm_r && cond[c] && !hist_r) pend_r <= 1'b1;
          else if (wr_clr && wdata[c])                pend_r <= 1'b0;
        end
      end
  end

  always_comb begin
    rdata = '0;
    if (aligned)
      case (addr[3:2])
        2'd0: for (int i = 0; i < 4; i++) rdata[i*8 +: SW] = sel_q[i];
        2'd1: for (int i = 0; i < 4; i++) rdata[i*8 +: SW] = sel_q[i+4];
        2'd2: begin
          rdata[7:0]   = edge_q;
          rdata[23:16] = pol_q;
        end
        default: rdata[7:0] = pend_q;
      endcase
  end
endmodule

module gpio_irq_mux_chk #(
  parameter int NUM_PADS  = 96,
  parameter int IDX_SPACE = 256
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                wr_en,
  input logic [3:0]                          addr,
  input logic [31:0]                         wdata,
  input logic [7:0]                          irq_out,
  input logic [7:0][$clog2(IDX_SPACE)-1:0]   sel_q,
  input logic [7:0]                          edge_q,
  input logic [7:0]                          pend_q
);
  localparam int SW = $clog2(IDX_SPACE);
  localparam logic [SW:0] PAD_LIM = (SW+1)'(NUM_PADS);

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> irq_out == 8'h00);

  for (genvar c = 0; c < 8; c++) begin : g_a
    p_pend_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[c] && !wr_en |=> pend_q[c]);
    p_set_in_edge_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[c]) |-> edge_q[c] && $past(edge_q[c]));
    p_level_no_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_q[c] |-> !pend_q[c]);
    p_unmapped_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, sel_q[c]} >= PAD_LIM |-> !irq_out[c]);
    p_mode_change_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 4'h8 && wdata[c] != edge_q[c] |=> !pend_q[c]);
  end
endmodule

bind gpio_irq_mux gpio_irq_mux_chk #(.NUM_PADS(NUM_PADS), .IDX_SPACE(IDX_SPACE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_out(irq_out), .sel_q(sel_q), .edge_q(edge_q), .pend_q(pend_q)
);

// File: tb/sim_gpio_irq_mux.sv
module sim_gpio_irq_mux;
  localparam int NP = 96;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pads = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  wire  [31:0]   rdata;
  wire  [7:0]    irq_out;

  always #10 clk = ~clk;

  gpio_irq_mux #(.NUM_PADS(NP), .IDX_SPACE(256)) u0 (
    .clk(clk), .rst_n(rst_n), .pads(pads), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_sel [8];
  logic [7:0] m_edge = '0, m_pol = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic setpad(int idx, logic v);
    @(negedge clk); pads[idx] = v;
  endtask

  function automatic logic [31:0] sel_word(int w);
    return {m_sel[4*w+3], m_sel[4*w+2], m_sel[4*w+1], m_sel[4*w]};
  endfunction

  function automatic logic exp_level(logic padv, logic pol, logic [7:0] s);
    return (s < NP) ? (padv ^ pol) : 1'b0;
  endfunction

  task automatic cfg(int c, logic [7:0] s, logic e, logic p);
    m_sel[c] = s;
    wr((c < 4) ? 4'h0 : 4'h4, sel_word(c / 4));
    m_edge[c] = e; m_pol[c] = p;
    wr(4'h8, {8'h00, m_pol, 8'h00, m_edge});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) m_sel[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle(1);

    check("R1 irq after reset", {24'h0, irq_out}, 32'h0);
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), d);
      check("R1 register reset", d, 32'h0);
    end

    cfg(0, 8'd7, 1'b0, 1'b0);
    cfg(5, 8'h2A, 1'b1, 1'b1);
    rd(4'h0, d); check("R2 sel word 0", d, 32'h0000_0007);
    rd(4'h4, d); check("R2 sel word 1", d, 32'h0000_2A00);
    rd(4'h8, d); check("R2 mode/polarity", d, 32'h0020_0020);

    setpad(7, 1'b1);
    settle(1); check("R3 level latency one edge", irq_out[0], 1'b0);
    settle(1); check("R3 level latency two edges", irq_out[0], 1'b1);
    wr(4'hC, 32'hFF);
    check("R6 clear ignored in level", irq_out[0], 1'b1);
    setpad(7, 1'b0);
    settle(2); check("R3 level follows low", irq_out[0], 1'b0);
    cfg(0, 8'd7, 1'b0, 1'b1);
    settle(2); check("R3 active-low level", irq_out[0], 1'b1);

    cfg(1, 8'd10, 1'b1, 1'b0);
    settle(3);
    setpad(10, 1'b1);
    settle(2); check("R4 edge before third edge", irq_out[1], 1'b0);
    settle(1); check("R4 edge on third edge", irq_out[1], 1'b1);
    setpad(10, 1'b0);
    settle(4); check("R4 sticky after pad drops", irq_out[1], 1'b1);
    rd(4'hC, d); check("R2 pending readback", d, 32'h0000_0002);
    wr(4'hC, 32'h2);
    check("R5 clear", irq_out[1], 1'b0);

    cfg(1, 8'd10, 1'b1, 1'b1);
    settle(4); check("R8 polarity change makes no edge", irq_out[1], 1'b0);
    setpad(10, 1'b1);
    settle(3); check("R4 rising ignored when falling", irq_out[1], 1'b0);
    setpad(10, 1'b0);
    settle(3); check("R4 falling edge", irq_out[1], 1'b1);
    wr(4'hC, 32'hFFFF_FFFD);
    check("R5 zero bit keeps pending", irq_out[1], 1'b1);
    setpad(10, 1'b1);
    settle(3);
    setpad(10, 1'b0);
    repeat (2) @(posedge clk);
    wr(4'hC, 32'h2);
    check("R5 set wins over clear", irq_out[1], 1'b1);
    wr(4'hC, 32'h2);
    check("R5 clear after race", irq_out[1], 1'b0);
    setpad(10, 1'b1);
    settle(3);
    setpad(10, 1'b0);
    settle(3);
    cfg(1, 8'd11, 1'b1, 1'b1);
    check("R8 sel change clears pending", irq_out[1], 1'b0);

    cfg(2, 8'd200, 1'b0, 1'b1);
    settle(3); check("R7 unmapped inactive low-level", irq_out[2], 1'b0);
    cfg(2, 8'd96, 1'b0, 1'b1);
    settle(3); check("R7 first unmapped index", irq_out[2], 1'b0);
    setpad(95, 1'b1);
    cfg(2, 8'd95, 1'b0, 1'b0);
    settle(2); check("R7 last mapped index", irq_out[2], 1'b1);

    setpad(30, 1'b1);
    settle(3);
    cfg(6, 8'd30, 1'b1, 1'b0);
    settle(4); check("R8 active pad at reconfig", irq_out[6], 1'b0);

    cfg(3, 8'd20, 1'b0, 1'b0);
    cfg(4, 8'd20, 1'b0, 1'b1);
    setpad(20, 1'b1);
    settle(2);
    check("R9 shared pad high channel", irq_out[3], 1'b1);
    check("R9 shared pad low channel", irq_out[4], 1'b0);

    for (int it = 0; it < 40; it++) begin
      int c;
      logic [7:0] s;
      logic e, p;
      c = int'($urandom % 8);
      s = ($urandom % 4 == 0) ? 8'(96 + $urandom % 160) : 8'($urandom % 96);
      e = 1'($urandom);
      p = 1'($urandom);
      if (s < NP) begin
        setpad(int'(s), p);
        settle(3);
      end
      cfg(c, s, e, p);
      wr(4'hC, 32'(1) << c);
      settle(3);
      check("R8 quiet after config", irq_out[c], 1'b0);
      if (s < NP) begin
        setpad(int'(s), ~p);
        settle(1); check("R3 R4 latency first edge", irq_out[c], 1'b0);
        if (e) begin
          settle(1); check("R4 latency second edge", irq_out[c], 1'b0);
        end
        settle(1); check("R3 R4 active", irq_out[c], e ? 1'b1 : exp_level(~p, p, s));
        setpad(int'(s), p);
        settle(3); check("R3 R4 after release", irq_out[c], e ? 1'b1 : 1'b0);
        if (e) begin
          wr(4'hC, 32'(1) << c);
          check("R5 random clear", irq_out[c], 1'b0);
        end
      end else begin
        @(negedge clk);
        pads = {$urandom, $urandom, $urandom};
        settle(3);
        check("R7 random unmapped", irq_out[c], 1'b0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule